// File: doc/BRIEF.md
# Flash Housekeeping Command Sequencer

This block runs the two fixed housekeeping commands a serial NOR flash needs between data transfers. It reads the flash status byte and sets the flash write-enable latch. No software-built frame is involved. A request strobe names the operation and a target bank. The sequencer then drives a shared serial shifter through a short start/done handshake and merges the result into one controller status word. That word holds the flash status byte, the controller event flags and one write-mode bit per bank.

A write-enable is confirmed by hardware. After the write-enable opcode, the sequencer reads the flash status itself and copies the write-enable latch into the bank's write-mode bit. Host software polls with repeated status reads until the write-in-progress bit drops. A read that shows both the busy bit and the latch clear, on a bank whose write-mode bit was set, marks the write as complete. Two completion flags can raise an interrupt through enable inputs. A clear strobe empties the whole status word.

Top module: `hk_cmd_seq`

## Requirements
- R1: After reset, `status` is all zero, `irq` is low and `shStart` is low.
- R2: A read-status request (`startRdSt`) with `swMode` and `wbMode` both low sends opcode 0x05 with `shRead`=1 to bank `reqBank`. The response byte is loaded into `status[7:0]`: bit 0 busy (write in progress), bit 1 write-enable latch, bits 4:2 block protect, bit 7 status-register protect.
- R3: Completion of either operation sets the transfer-finished flag `status[8]`.
- R4: A write-enable request (`startWrEn`) sends opcode 0x06 with `shRead`=0, then a confirming 0x05 read of the same bank. `status[12+bank]` takes bit 1 of that response, and `status[7:0]` is left unchanged.
- R5: A read-status request while `swMode` or `wbMode` is high issues no command and sets the forbidden-access flag `status[11]`.
- R6: A write-enable request while `swMode` is high issues no command and sets the forbidden-write flag `status[10]`. `wbMode` alone does not block a write-enable.
- R7: A pulse on `stClr` with no event in that cycle clears every bit of `status`.
- R8: `irq` equals (`status[8]` and `ieTff`) or (`status[9]` and `ieWc`).
- R9: Every status read updates `status[12+bank]` from response bit 1. If that bit was set and the response has bits 1:0 both zero, the write-complete flag `status[9]` is set.
- R10: Requests are ignored while a sequence is in progress. When both requests arrive in the same idle cycle, only the read-status runs.
- R11: `shStart` is a one-cycle pulse, and `shOpcode` and `shBank` stay stable while a command waits for `shDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startRdSt | input | 1 | Request a flash status read |
| startWrEn | input | 1 | Request a write-enable |
| reqBank | input | 2 | Target bank of the request |
| swMode | input | 1 | Software frame mode active |
| wbMode | input | 1 | Write-burst mode active |
| ieTff | input | 1 | Interrupt enable for transfer finished |
| ieWc | input | 1 | Interrupt enable for write complete |
| stClr | input | 1 | Clear the whole status word |
| shDone | input | 1 | Shifter finished the current command |
| shRxData | input | 8 | Byte returned by the shifter |
| shStart | output | 1 | Start pulse to the shifter |
| shOpcode | output | 8 | Opcode for the shifter |
| shRead | output | 1 | One response byte expected |
| shBank | output | 2 | Bank select for the shifter |
| status | output | 16 | Merged controller status word |
| irq | output | 1 | Interrupt request |

## Verification
The write-complete flag is the hardest state to reach from the ports. It needs three things in order: a confirmed write-enable that sets the bank's write-mode bit, a flash that reports busy for several reads, and a final read where both the busy bit and the latch have dropped. The bench's flash model keeps a per-bank countdown of busy reads. It clears the latch when the countdown runs out, and the bench polls the way host software does, counting the reads needed. The same model can refuse a write-enable, which covers the unconfirmed path.

// File: rtl/hk_cmd_seq_pkg.sv
package hk_cmd_seq_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  localparam int TFF_BIT  = 8;
  localparam int WCF_BIT  = 9;
  localparam int FWR_BIT  = 10;
  localparam int FACC_BIT = 11;
  localparam int WM_BASE  = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RS_WAIT,
    ST_WE_WAIT,
    ST_WE_CHK
  } seqState_t;

  typedef struct packed {
    logic tffSet;
    logic loadLow;
    logic wmUpdate;
    logic fwrSet;
    logic faccSet;
  } seqStrobe_t;
endpackage

// File: rtl/hk_cmd_seq_ctrl.sv
module hk_cmd_seq_ctrl
  import hk_cmd_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRdSt,
  input  logic              startWrEn,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              swMode,
  input  logic              wbMode,
  input  logic              shDone,
  output logic              shStart,
  output logic [7:0]        shOpcode,
  output logic              shRead,
  output logic [BANK_W-1:0] shBank,
  output seqStrobe_t        strb
);
  seqState_t state;
  logic rsBlocked;
  logic weBlocked;

  assign rsBlocked = swMode | wbMode;
  assign weBlocked = swMode;

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (startRdSt) strb.faccSet = rsBlocked;
        else if (startWrEn) strb.fwrSet = weBlocked;
      end
      ST_RS_WAIT: begin
        strb.loadLow  = shDone;
        strb.wmUpdate = shDone;
        strb.tffSet   = shDone;
      end
      ST_WE_CHK: begin
        strb.wmUpdate = shDone;
        strb.tffSet   = shDone;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      shStart  <= 1'b0;
      shOpcode <= '0;
      shRead   <= 1'b0;
      shBank   <= '0;
    end else begin
      shStart <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startRdSt) begin
            if (!rsBlocked) begin
              state    <= ST_RS_WAIT;
              shStart  <= 1'b1;
              shOpcode <= OP_RDSR;
              shRead   <= 1'b1;
              shBank   <= reqBank;
            end
          end else if (startWrEn && !weBlocked) begin
            state    <= ST_WE_WAIT;
            shStart  <= 1'b1;
            shOpcode <= OP_WREN;
            shRead   <= 1'b0;
            shBank   <= reqBank;
          end
        end
        ST_WE_WAIT: begin
          if (shDone) begin
            state    <= ST_WE_CHK;
            shStart  <= 1'b1;
            shOpcode <= OP_RDSR;
            shRead   <= 1'b1;
          end
        end
        ST_RS_WAIT, ST_WE_CHK: begin
          if (shDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    shStart |=> !shStart); // R11
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !shDone) |=> ($stable(shOpcode) && $stable(shBank))); // R11
  AST_RS_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startRdSt && rsBlocked) |=> !shStart); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RS_WAIT || state == ST_WE_CHK) |=> !shStart); // R10
endmodule

// File: rtl/hk_cmd_seq_dpath.sv
module hk_cmd_seq_dpath
  import hk_cmd_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int STATUS_W = WM_BASE + NUM_BANKS
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strb,
  input  logic [BANK_W-1:0]   bank,
  input  logic [7:0]          rxData,
  input  logic                stClr,
  input  logic                ieTff,
  input  logic                ieWc,
  output logic [STATUS_W-1:0] status,
  output logic                irq
);
  logic [STATUS_W-1:0] statusNext;
  logic                wmOld;

  assign wmOld = status[WM_BASE + int'(bank)];

  always_comb begin
    statusNext = stClr ? '0 : status;
    if (strb.loadLow) statusNext[7:0] = rxData;
    if (strb.wmUpdate) begin
      statusNext[WM_BASE + int'(bank)] = rxData[1];
      if (wmOld && rxData[1:0] == 2'b00) statusNext[WCF_BIT] = 1'b1;
    end
    if (strb.tffSet)  statusNext[TFF_BIT]  = 1'b1;
    if (strb.fwrSet)  statusNext[FWR_BIT]  = 1'b1;
    if (strb.faccSet) statusNext[FACC_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= statusNext;
  end

  assign irq = (status[TFF_BIT] & ieTff) | (status[WCF_BIT] & ieWc);

  AST_TFF_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.tffSet |=> status[TFF_BIT]); // R3
  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLow |=> (status[7:0] == $past(rxData))); // R2
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (stClr && strb == '0) |=> (status == '0)); // R7
endmodule

// File: rtl/hk_cmd_seq.sv
module hk_cmd_seq
  import hk_cmd_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int STATUS_W = WM_BASE + NUM_BANKS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startRdSt,
  input  logic                startWrEn,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic                swMode,
  input  logic                wbMode,
  input  logic                ieTff,
  input  logic                ieWc,
  input  logic                stClr,
  input  logic                shDone,
  input  logic [7:0]          shRxData,
  output logic                shStart,
  output logic [7:0]          shOpcode,
  output logic                shRead,
  output logic [BANK_W-1:0]   shBank,
  output logic [STATUS_W-1:0] status,
  output logic                irq
);
  seqStrobe_t strb;

  hk_cmd_seq_ctrl #(.NUM_BANKS(NUM_BANKS)) uCtrl (
    .clk(clk), .rstN(rstN), .startRdSt(startRdSt), .startWrEn(startWrEn),
    .reqBank(reqBank), .swMode(swMode), .wbMode(wbMode), .shDone(shDone),
    .shStart(shStart), .shOpcode(shOpcode), .shRead(shRead), .shBank(shBank),
    .strb(strb)
  );

  hk_cmd_seq_dpath #(.NUM_BANKS(NUM_BANKS)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .bank(shBank), .rxData(shRxData),
    .stClr(stClr), .ieTff(ieTff), .ieWc(ieWc), .status(status), .irq(irq)
  );

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!ieTff && !ieWc) |-> !irq); // R8
endmodule

// File: tb/hk_cmd_seq_test.sv
module hk_cmd_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startRdSt = 1'b0, startWrEn = 1'b0;
  logic [1:0] reqBank = '0;
  logic swMode = 1'b0, wbMode = 1'b0, ieTff = 1'b0, ieWc = 1'b0, stClr = 1'b0;
  logic shDone = 1'b0;
  logic [7:0] shRxData = '0;
  logic shStart, shRead, irq;
  logic [7:0] shOpcode;
  logic [1:0] shBank;
  logic [15:0] status;

  int errors = 0, checks = 0;
  int cmdCount = 0, doneCount = 0;
  logic [7:0] lastOp;
  logic [1:0] lastBank;
  logic lastRead;
  int busyCnt[4];
  bit wel[4];
  bit refuseWe[4];
  logic [7:0] prot[4];
  bit finished = 0;

  always #10 clk = ~clk;

  hk_cmd_seq uut (
    .clk(clk), .rstN(rstN), .startRdSt(startRdSt), .startWrEn(startWrEn),
    .reqBank(reqBank), .swMode(swMode), .wbMode(wbMode), .ieTff(ieTff),
    .ieWc(ieWc), .stClr(stClr), .shDone(shDone), .shRxData(shRxData),
    .shStart(shStart), .shOpcode(shOpcode), .shRead(shRead), .shBank(shBank),
    .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // serial shifter plus flash model, driven at falling edges
  initial begin
    forever begin
      @(negedge clk);
      shDone = 1'b0;
      if (shStart) begin
        automatic logic [7:0] op = shOpcode;
        automatic int b = int'(shBank);
        cmdCount++;
        lastOp = op; lastBank = shBank; lastRead = shRead;
        repeat (2) @(negedge clk);
        if (op == 8'h06) begin
          if (!refuseWe[b]) wel[b] = 1;
          shRxData = 8'h00;
        end else begin
          shRxData = prot[b] | {6'b0, wel[b], (busyCnt[b] > 0)};
          if (busyCnt[b] > 0) begin
            busyCnt[b]--;
            if (busyCnt[b] == 0) wel[b] = 0;
          end
        end
        shDone = 1'b1;
        doneCount++;
      end
    end
  end

  task automatic waitDones(input int n);
    automatic int target = doneCount + n;
    automatic int guard = 0;
    while (doneCount < target && guard < 200) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reqRs(input int b);
    @(negedge clk); reqBank = 2'(b); startRdSt = 1'b1;
    @(negedge clk); startRdSt = 1'b0;
  endtask

  task automatic reqWe(input int b);
    @(negedge clk); reqBank = 2'(b); startWrEn = 1'b1;
    @(negedge clk); startWrEn = 1'b0;
  endtask

  task automatic clearSt();
    @(negedge clk); stClr = 1'b1;
    @(negedge clk); stClr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int b = 0; b < 4; b++) begin
      busyCnt[b] = 0; wel[b] = 0; refuseWe[b] = 0;
      prot[b] = ((b & 1) ? 8'h80 : 8'h00) | 8'(((b + 1) & 7) << 2);
    end
    repeat (3) @(negedge clk);
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 shStart", 32'(shStart), 32'h0);
    rstN = 1'b1;

    // R2/R3: status read sweep over all banks
    for (int b = 0; b < 4; b++) begin
      clearSt();
      reqRs(b);
      waitDones(1);
      chk("R2 opcode", 32'(lastOp), 32'h05);
      chk("R2 bank", 32'(lastBank), 32'(b));
      chk("R2 read", 32'(lastRead), 32'h1);
      chk("R2 R3 status", 32'(status), 32'h0100 | 32'(prot[b]));
    end

    // R4: write-enable sweep, write-mode bits accumulate
    clearSt();
    for (int b = 0; b < 4; b++) begin
      automatic int c0 = cmdCount;
      reqWe(b);
      waitDones(2);
      chk("R4 commands", 32'(cmdCount - c0), 32'd2);
      chk("R4 confirm op", 32'(lastOp), 32'h05);
      chk("R4 status", 32'(status), 32'h0100 | ((32'h1 << (b + 1)) - 1) << 12);
    end

    // R4: refused write-enable leaves bit clear
    clearSt();
    wel[1] = 0; refuseWe[1] = 1;
    reqWe(1);
    waitDones(2);
    chk("R4 refused", 32'(status), 32'h0100);

    // R5: read-status blocked by either mode
    clearSt();
    begin
      automatic int c0 = cmdCount;
      swMode = 1'b1; reqRs(0); repeat (6) @(negedge clk);
      chk("R5 sw no cmd", 32'(cmdCount - c0), 32'd0);
      chk("R5 sw flag", 32'(status), 32'h0800);
      swMode = 1'b0; clearSt();
      wbMode = 1'b1; reqRs(0); repeat (6) @(negedge clk);
      chk("R5 wb no cmd", 32'(cmdCount - c0), 32'd0);
      chk("R5 wb flag", 32'(status), 32'h0800);
      // R6: write-burst does not block write-enable
      clearSt();
      reqWe(3); waitDones(2);
      chk("R6 wb allows", 32'(cmdCount - c0), 32'd2);
      chk("R6 wb status", 32'(status), 32'h8100);
      wbMode = 1'b0;
      clearSt();
      c0 = cmdCount;
      swMode = 1'b1; reqWe(0); repeat (6) @(negedge clk);
      chk("R6 sw no cmd", 32'(cmdCount - c0), 32'd0);
      chk("R6 sw flag", 32'(status), 32'h0400);
      swMode = 1'b0;
    end

    // R7: clear
    clearSt();
    @(negedge clk);
    chk("R7 clear", 32'(status), 32'h0);

    // R9: polling a busy flash after write-enable
    reqWe(2);
    waitDones(2);
    chk("R9 wm set", 32'(status), 32'h4100);
    busyCnt[2] = 3;
    begin
      automatic int reads = 0;
      do begin
        reqRs(2); waitDones(1); reads++;
      end while (status[0] && reads < 10);
      chk("R9 read count", 32'(reads), 32'd4);
      chk("R9 wcf", 32'(status[9]), 32'h1);
      chk("R9 wm cleared", 32'(status[14]), 32'h0);
      chk("R9 low byte", 32'(status[7:0]), 32'(prot[2]));
    end

    // R8: interrupt gating
    ieTff = 1'b0; ieWc = 1'b0; @(negedge clk);
    chk("R8 none", 32'(irq), 32'h0);
    ieWc = 1'b1; @(negedge clk);
    chk("R8 wc", 32'(irq), 32'h1);
    clearSt(); @(negedge clk);
    chk("R8 cleared", 32'(irq), 32'h0);
    ieWc = 1'b0; ieTff = 1'b1;
    reqRs(0); waitDones(1);
    chk("R8 tff", 32'(irq), 32'h1);
    ieTff = 1'b0;

    // R10: request during a sequence ignored
    clearSt();
    begin
      automatic int c0 = cmdCount;
      reqRs(3); reqWe(0);
      waitDones(1); repeat (10) @(negedge clk);
      chk("R10 busy ignore", 32'(cmdCount - c0), 32'd1);
      chk("R10 busy op", 32'(lastOp), 32'h05);
      chk("R10 busy status", 32'(status), 32'h8192);
      clearSt();
      c0 = cmdCount;
      @(negedge clk); reqBank = 2'd1; startRdSt = 1'b1; startWrEn = 1'b1;
      @(negedge clk); startRdSt = 1'b0; startWrEn = 1'b0;
      waitDones(1); repeat (10) @(negedge clk);
      chk("R10 both count", 32'(cmdCount - c0), 32'd1);
      chk("R10 both op", 32'(lastOp), 32'h05);
      chk("R10 both status", 32'(status), 32'h0188);
    end

    summary();
  end
endmodule